// File: doc/BRIEF.md
# PCI Bus Arbiter with CPU Fairness

This block decides which requester owns a shared PCI-style bus. One host CPU requester and five PCI master request lines compete, and the block answers with one-hot grant lines. It holds no grant while nobody is asking. Between two owners it always leaves one clock with every grant low, so the bus can turn around.

A set of static configuration inputs sets the policy:
- **Release trigger:** whether the bus may change hands only when the owner withdraws its request, or also as soon as the owner starts a transaction by driving the active-low frame line.
- **Master time-out:** a limit, in multiples of 16 clocks, on how long a PCI master may hold the bus before it is forced back into arbitration.
- **CPU fairness:** the CPU can be guaranteed the bus after every one, two or three completed PCI master tenures, even while the masters keep requesting.
- **Priority slot:** the lowest-priority master slot can be fed from a different physical request line, and that slot can be raised to top priority.

Top module: `pci_fair_arbiter`

## Requirements
- R1: While reset (rstN low) is asserted, every grant output is low, and both the time-out count and the fairness count are cleared.
- R2: At most one grant output is high in any cycle. A grant is removed on the clock edge that samples its release condition. A new grant can appear no earlier than the following edge, so there is at least one cycle with all grants low between any two grants.
- R3: With no request active, every grant stays low. A grant is only given, one clock after an idle cycle, to a line that was requesting at that edge.
- R4: With slotHiPri at 0, the winner is picked from slot 0 (highest) through slot 4, and the CPU ranks below every PCI slot.
- R5: With slotHiPri at 1, slot 4 outranks every other slot. The rest keep the order of R4.
- R6: slotMap selects the physical line that feeds slot 4, and the displaced line takes that line's slot: 0 selects REQ4 (no swap), 1 selects REQ0, 2 selects REQ1, 3 selects REQ2. Grants go back to the physical line.
- R7: With arbOnFrame at 0, an owner keeps the grant until its own request goes low, and frameN has no effect.
- R8: With arbOnFrame at 1, the grant is also released when frameN is sampled low while a grant is held.
- R9: For a timeout code N from 1 to 7, a PCI master's grant stays high for exactly N*16 cycles and is then released even though the master keeps requesting. Code 0 disables the limit. A CPU grant is never timed out.
- R10: For a rotation code K from 1 to 3, once K PCI master grants have completed since the last CPU grant, the next grant goes to the CPU if it requests. Until then, requesting masters are served by priority. Code 0 disables this.
- R11: If a forced CPU turn is due but the CPU is not requesting, masters keep being served by priority. The CPU takes the next grant once it requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Host CPU bus request |
| pciReq | input | NUM_PCI | PCI master request lines, index is the physical line |
| frameN | input | 1 | Active-low transaction start seen on the bus |
| arbOnFrame | input | 1 | 1: frameN low also releases the grant |
| tmoSel | input | TMO_BITS | Master time-out code, 0 disables |
| rotateSel | input | 2 | CPU turn after this many master grants, 0 disables |
| slotMap | input | 2 | Physical line that feeds slot 4 |
| slotHiPri | input | 1 | 1: slot 4 has top priority |
| cpuGnt | output | 1 | CPU grant |
| pciGnt | output | NUM_PCI | PCI master grants, index is the physical line |

## Verification
The bench builds the arbiter with its default parameters: five masters, a 16-clock time-out step and a 3-bit time-out code. With these values even the longest time-out (112 cycles) fits in a short run, so the hold time of codes 1, 2 and 7 is counted exactly, along with the disabled code. A frame pulser that ends every tenure after two cycles keeps the masters requesting without pause. Against that traffic, the grant order for every rotation code is compared with a queue of expected owners.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadGrant;   // register the current winner
    logic dropGrant;   // clear the grant register
    logic forceCpu;    // the CPU wins this arbitration
  } arbStrobe_t;

  // state reported by the datapath to control
  typedef struct packed {
    logic anyReq;       // some line requests
    logic holding;      // a grant is held
    logic ownerIsPci;   // holder is a PCI master
    logic ownerIsCpu;   // holder is the CPU
    logic ownerReqLive; // holder still requests
    logic winnerIsCpu;  // CPU would win an arbitration now
  } arbStatus_t;

endpackage

// File: rtl/pci_arb_datapath.sv
module pci_arb_datapath
  import pci_arb_pkg::*;
#(
  parameter int NUM_PCI = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuReq,
  input  logic [NUM_PCI-1:0] pciReq,
  input  logic [1:0]         slotMap,
  input  logic               slotHiPri,
  input  arbStrobe_t         strobe,
  output arbStatus_t         status,
  output logic               cpuGnt,
  output logic [NUM_PCI-1:0] pciGnt
);

  localparam int LAST  = NUM_PCI - 1;
  localparam int IDX_W = $clog2(NUM_PCI);
  localparam int GNT_W = NUM_PCI + 1;

  logic [IDX_W-1:0]   swapLine;
  logic [NUM_PCI-1:0] slotReq;
  logic [NUM_PCI-1:0] winSlot;
  logic [NUM_PCI-1:0] winLine;
  logic               winCpu;
  logic [GNT_W-1:0]   gntQ;
  logic [GNT_W-1:0]   reqVec;

  // physical line moved into the last slot
  always_comb begin
    if (slotMap == 2'd0) swapLine = IDX_W'(LAST);
    else                 swapLine = IDX_W'(slotMap) - IDX_W'(1);
  end

  // swap slot LAST with swapLine (its own inverse)
  for (genvar s = 0; s < NUM_PCI; s++) begin : g_slot
    if (s == LAST) begin : g_last
      assign slotReq[s] = pciReq[swapLine];
      assign winLine[s] = winSlot[swapLine];
    end else begin : g_other
      assign slotReq[s] = (swapLine == IDX_W'(s)) ? pciReq[LAST] : pciReq[s];
      assign winLine[s] = (swapLine == IDX_W'(s)) ? winSlot[LAST] : winSlot[s];
    end
  end

  // priority pick
  always_comb begin
    logic found;
    winSlot = '0;
    winCpu  = 1'b0;
    found   = 1'b0;
    if (strobe.forceCpu) begin
      winCpu = 1'b1;
    end else if (slotHiPri && slotReq[LAST]) begin
      winSlot[LAST] = 1'b1;
    end else begin
      for (int s = 0; s < NUM_PCI; s++) begin
        if (!found && slotReq[s]) begin
          winSlot[s] = 1'b1;
          found      = 1'b1;
        end
      end
      if (!found && cpuReq) winCpu = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 gntQ <= '0;
    else if (strobe.dropGrant) gntQ <= '0;
    else if (strobe.loadGrant) gntQ <= {winCpu, winLine};
  end

  assign reqVec = {cpuReq, pciReq};

  always_comb begin
    status.anyReq       = |reqVec;
    status.holding      = |gntQ;
    status.ownerIsCpu   = gntQ[NUM_PCI];
    status.ownerIsPci   = |gntQ[LAST:0];
    status.ownerReqLive = |(gntQ & reqVec);
    status.winnerIsCpu  = winCpu;
  end

  assign cpuGnt = gntQ[NUM_PCI];
  assign pciGnt = gntQ[LAST:0];

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntQ));

  // R2
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|gntQ) |=> ((gntQ == $past(gntQ)) || (gntQ == '0)));

  // R3
  grant_to_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|gntQ) |-> (|(gntQ & $past(reqVec))));

  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(|gntQ) && !(|reqVec)) |=> (gntQ == '0));

endmodule

// File: rtl/pci_arb_ctrl.sv
module pci_arb_ctrl
  import pci_arb_pkg::*;
#(
  parameter int TMO_STEP = 16,
  parameter int TMO_BITS = 3,
  parameter int ROT_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  arbStatus_t          status,
  input  logic                cpuReq,
  input  logic                frameN,
  input  logic                arbOnFrame,
  input  logic [TMO_BITS-1:0] tmoSel,
  input  logic [ROT_W-1:0]    rotateSel,
  output arbStrobe_t          strobe
);

  localparam int TMO_MAX = ((1 << TMO_BITS) - 1) * TMO_STEP;
  localparam int CNT_W   = $clog2(TMO_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(TMO_MAX);
  localparam logic [ROT_W-1:0] PASS_TOP = '1;

  logic [CNT_W-1:0] tmoCnt;
  logic [CNT_W-1:0] tmoLimit;
  logic [ROT_W-1:0] passCnt;
  logic             tmoHit;
  logic             releaseNow;
  logic             cpuDue;

  assign tmoLimit = CNT_W'(32'(tmoSel) * TMO_STEP);

  always_comb begin
    tmoHit = status.holding && status.ownerIsPci && (tmoSel != '0) &&
             (tmoCnt >= tmoLimit - CNT_W'(1));
    releaseNow = status.holding &&
                 (!status.ownerReqLive || (arbOnFrame && !frameN) || tmoHit);
    cpuDue = (rotateSel != '0) && (passCnt >= rotateSel);
    strobe.dropGrant = releaseNow;
    strobe.loadGrant = !status.holding && status.anyReq;
    strobe.forceCpu  = cpuDue && cpuReq;
  end

  // ownership time of a PCI master
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      tmoCnt <= '0;
    else if (strobe.loadGrant)
      tmoCnt <= '0;
    else if (status.holding && status.ownerIsPci && tmoCnt != CNT_TOP)
      tmoCnt <= tmoCnt + CNT_W'(1);
  end

  // completed master tenures since the last CPU grant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      passCnt <= '0;
    else if (strobe.loadGrant && status.winnerIsCpu)
      passCnt <= '0;
    else if (releaseNow && status.ownerIsPci && passCnt != PASS_TOP)
      passCnt <= passCnt + ROT_W'(1);
  end

  // R9
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status.holding && status.ownerIsPci && tmoSel != '0 && $stable(tmoSel))
      |-> (tmoCnt < tmoLimit));

  // R10
  cpu_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!status.holding && cpuReq && cpuDue) |=> status.ownerIsCpu);

  // R10
  pass_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status.ownerIsCpu && $rose(status.holding)) |-> (passCnt == '0));

endmodule

// File: rtl/pci_fair_arbiter.sv
module pci_fair_arbiter
  import pci_arb_pkg::*;
#(
  parameter int NUM_PCI  = 5,
  parameter int TMO_STEP = 16,
  parameter int TMO_BITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuReq,
  input  logic [NUM_PCI-1:0]  pciReq,
  input  logic                frameN,
  input  logic                arbOnFrame,
  input  logic [TMO_BITS-1:0] tmoSel,
  input  logic [1:0]          rotateSel,
  input  logic [1:0]          slotMap,
  input  logic                slotHiPri,
  output logic                cpuGnt,
  output logic [NUM_PCI-1:0]  pciGnt
);

  arbStrobe_t strobe;
  arbStatus_t status;

  pci_arb_ctrl #(
    .TMO_STEP(TMO_STEP),
    .TMO_BITS(TMO_BITS),
    .ROT_W   (2)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .status    (status),
    .cpuReq    (cpuReq),
    .frameN    (frameN),
    .arbOnFrame(arbOnFrame),
    .tmoSel    (tmoSel),
    .rotateSel (rotateSel),
    .strobe    (strobe)
  );

  pci_arb_datapath #(
    .NUM_PCI(NUM_PCI)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .pciReq   (pciReq),
    .slotMap  (slotMap),
    .slotHiPri(slotHiPri),
    .strobe   (strobe),
    .status   (status),
    .cpuGnt   (cpuGnt),
    .pciGnt   (pciGnt)
  );

endmodule

// File: tb/tb_pci_fair_arbiter.sv
`timescale 1ns/1ps
module tb_pci_fair_arbiter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuReq = 1'b0;
  logic [4:0] pciReq = '0;
  logic       frameN;
  logic       arbOnFrame = 1'b0;
  logic [2:0] tmoSel = '0;
  logic [1:0] rotateSel = '0;
  logic [1:0] slotMap = '0;
  logic       slotHiPri = 1'b0;
  logic       cpuGnt;
  logic [4:0] pciGnt;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit scoreOn = 0;
  bit autoFrame = 0;
  bit manualFrame = 0;

  logic [5:0] expQ[$];
  string      tagQ[$];
  logic [5:0] prevGnt = '0;
  logic [5:0] expG;
  string      expTag;
  int         heldCnt = 0;
  logic [5:0] gntNow;

  localparam logic [5:0] G0  = 6'b000001;
  localparam logic [5:0] G1  = 6'b000010;
  localparam logic [5:0] G2  = 6'b000100;
  localparam logic [5:0] G3  = 6'b001000;
  localparam logic [5:0] G4  = 6'b010000;
  localparam logic [5:0] GC  = 6'b100000;

  always #10 clk = ~clk;

  pci_fair_arbiter dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .pciReq(pciReq), .frameN(frameN),
    .arbOnFrame(arbOnFrame), .tmoSel(tmoSel), .rotateSel(rotateSel),
    .slotMap(slotMap), .slotHiPri(slotHiPri), .cpuGnt(cpuGnt), .pciGnt(pciGnt)
  );

  assign gntNow = {cpuGnt, pciGnt};

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard compare, one-hot and turnaround, frame pulser
  always @(negedge clk) begin
    if (rstN) begin
      if (scoreOn && gntNow != '0 && prevGnt == '0) begin
        if (expQ.size() == 0) begin
          check("R10 unexpected grant", int'(gntNow), 0);
        end else begin
          expG   = expQ.pop_front();
          expTag = tagQ.pop_front();
          check(expTag, int'(gntNow), int'(expG));
        end
      end
      if ($countones(gntNow) > 1) check("R2 one-hot", int'(gntNow), 0);
      if (gntNow != '0 && prevGnt != '0 && gntNow != prevGnt)
        check("R2 turnaround", int'(gntNow), 0);
    end
    if (gntNow != '0) heldCnt = (prevGnt == gntNow) ? heldCnt + 1 : 1;
    else              heldCnt = 0;
    frameN  = !((autoFrame && heldCnt == 2) || manualFrame);
    prevGnt = gntNow;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic quiesce();
    scoreOn   = 0;
    autoFrame = 0;
    pciReq    = '0;
    cpuReq    = 1'b0;
    tick(4);
  endtask

  task automatic pushExp(logic [5:0] g, string tag);
    expQ.push_back(g);
    tagQ.push_back(tag);
  endtask

  task automatic drainQ(string tag);
    for (int w = 0; w < 600 && expQ.size() != 0; w++) tick(1);
    check({tag, " queue drained"}, expQ.size(), 0);
    expQ.delete();
    tagQ.delete();
  endtask

  task automatic firstGrant(logic [4:0] req, logic cpu, logic [5:0] exp, string tag);
    pciReq = req;
    cpuReq = cpu;
    tick(1);
    check(tag, int'(gntNow), int'(exp));
    quiesce();
  endtask

  task automatic measureHold(output int n);
    n = 0;
    while (gntNow != '0 && n < 400) begin
      n++;
      tick(1);
    end
  endtask

  initial begin
    frameN = 1'b1;
    // R1: reset holds grants low despite requests
    pciReq = 5'b11111;
    cpuReq = 1'b1;
    tick(3);
    check("R1 grants in reset", int'(gntNow), 0);
    pciReq = '0;
    cpuReq = 1'b0;
    doReset();
    // R3: no requests, no grant
    tick(3);
    check("R3 idle no grant", int'(gntNow), 0);

    // R4 fixed order
    firstGrant(5'b11111, 1'b1, G0, "R4 all request");
    firstGrant(5'b10000, 1'b1, G4, "R4 slot4 over CPU");
    firstGrant(5'b01100, 1'b0, G2, "R4 two masters");
    firstGrant(5'b00000, 1'b1, GC, "R4 CPU alone");
    // R5 high priority slot
    slotHiPri = 1'b1;
    firstGrant(5'b11111, 1'b1, G4, "R5 slot4 first");
    // R6 remapping
    slotMap = 2'd1;
    firstGrant(5'b00011, 1'b0, G0, "R6 map1 hi REQ0");
    slotMap = 2'd2;
    firstGrant(5'b00011, 1'b0, G1, "R6 map2 hi REQ1");
    slotMap = 2'd3;
    firstGrant(5'b00101, 1'b0, G2, "R6 map3 hi REQ2");
    slotHiPri = 1'b0;
    firstGrant(5'b01100, 1'b0, G3, "R6 map3 REQ2 demoted");
    firstGrant(5'b11000, 1'b0, G4, "R6 map3 REQ4 in slot2");
    slotMap = 2'd1;
    firstGrant(5'b10001, 1'b0, G4, "R6 map1 REQ4 in slot0");
    slotMap = 2'd0;

    // R7 release by request only
    doReset();
    pciReq = 5'b01001;
    tick(1);
    check("R7 first owner", int'(gntNow), int'(G0));
    manualFrame = 1;
    tick(2);
    manualFrame = 0;
    check("R7 frame ignored", int'(gntNow), int'(G0));
    pciReq[0] = 1'b0;
    tick(1);
    check("R2 idle turnaround", int'(gntNow), 0);
    tick(1);
    check("R7 next owner", int'(gntNow), int'(G3));
    quiesce();

    // R8 release on frame
    arbOnFrame = 1'b1;
    doReset();
    pciReq = 5'b01001;
    tick(1);
    check("R8 first owner", int'(gntNow), int'(G0));
    manualFrame = 1;
    tick(1);
    manualFrame = 0;
    check("R8 released on frame", int'(gntNow), 0);
    tick(1);
    check("R8 regranted", int'(gntNow), int'(G0));
    quiesce();
    arbOnFrame = 1'b0;

    // R9 time-out
    begin
      int held;
      tmoSel = 3'd1;
      doReset();
      pciReq = 5'b00100;
      tick(1);
      measureHold(held);
      check("R9 code1 hold", held, 16);
      tick(1);
      check("R9 regrant after timeout", int'(gntNow), int'(G2));
      quiesce();
      tmoSel = 3'd2;
      doReset();
      pciReq = 5'b00100;
      tick(1);
      measureHold(held);
      check("R9 code2 hold", held, 32);
      quiesce();
      tmoSel = 3'd7;
      doReset();
      pciReq = 5'b00100;
      tick(1);
      measureHold(held);
      check("R9 code7 hold", held, 112);
      quiesce();
      tmoSel = 3'd0;
      doReset();
      pciReq = 5'b00100;
      tick(200);
      check("R9 code0 no timeout", int'(gntNow), int'(G2));
      quiesce();
      tmoSel = 3'd1;
      doReset();
      cpuReq = 1'b1;
      tick(60);
      check("R9 CPU exempt", int'(gntNow), int'(GC));
      quiesce();
      tmoSel = 3'd0;
    end

    // R10 rotation, frame pulser ends each tenure
    arbOnFrame = 1'b1;
    rotateSel = 2'd1;
    doReset();
    pushExp(G1, "R10 k1 m1"); pushExp(GC, "R10 k1 cpu");
    pushExp(G1, "R10 k1 m2"); pushExp(GC, "R10 k1 cpu2");
    pushExp(G1, "R10 k1 m3");
    scoreOn = 1; autoFrame = 1;
    pciReq = 5'b01010; cpuReq = 1'b1;
    drainQ("R10 k1");
    quiesce();

    rotateSel = 2'd2;
    doReset();
    pushExp(G1, "R10 k2 m1"); pushExp(G1, "R10 k2 m2"); pushExp(GC, "R10 k2 cpu");
    pushExp(G1, "R10 k2 m3"); pushExp(G1, "R10 k2 m4"); pushExp(GC, "R10 k2 cpu2");
    scoreOn = 1; autoFrame = 1;
    pciReq = 5'b01010; cpuReq = 1'b1;
    drainQ("R10 k2");
    quiesce();

    rotateSel = 2'd3;
    doReset();
    pushExp(G1, "R10 k3 m1"); pushExp(G1, "R10 k3 m2"); pushExp(G1, "R10 k3 m3");
    pushExp(GC, "R10 k3 cpu"); pushExp(G1, "R10 k3 m4");
    scoreOn = 1; autoFrame = 1;
    pciReq = 5'b01010; cpuReq = 1'b1;
    drainQ("R10 k3");
    quiesce();

    rotateSel = 2'd0;
    doReset();
    pushExp(G1, "R10 off m1"); pushExp(G1, "R10 off m2");
    pushExp(G1, "R10 off m3"); pushExp(G1, "R10 off m4");
    scoreOn = 1; autoFrame = 1;
    pciReq = 5'b01010; cpuReq = 1'b1;
    drainQ("R10 off");
    quiesce();

    // R11 skipped turn, then CPU joins
    rotateSel = 2'd1;
    doReset();
    pushExp(G2, "R11 skip m1"); pushExp(G2, "R11 skip m2"); pushExp(G2, "R11 skip m3");
    scoreOn = 1; autoFrame = 1;
    pciReq = 5'b10100; cpuReq = 1'b0;
    drainQ("R11 skip");
    pushExp(GC, "R11 CPU joins");
    cpuReq = 1'b1;
    drainQ("R11 join");
    quiesce();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule